// File: doc/BRIEF.md
# Compare Match Timer Channel

A multi-channel compare timer controlled over a simple register bus. Each channel has an up-counter, a compare register and a control/status register. A counter is 16 or 32 bits wide, chosen per channel by a parameter. The counter advances on prescaled ticks of the block clock. When the count equals the compare value, the counter returns to zero on that tick and a match flag is raised. The match flag drives the channel's interrupt line when the channel's interrupt enable is set.

One start/stop register is shared by all channels and holds one run bit per channel. Software sets the compare value, picks a prescale ratio, clears the counter, and then sets the channel's run bit. Flags are acknowledged by writing the control/status register with the flag bits at zero. A write to a counter does not take effect at once. It is held pending until the second pulse of a slow reference strobe after the write, and until then reads still return the running count. The register bus is a plain single-cycle strobe interface with no back-pressure: a write completes on the clock edge where `wr_en` is high, and `rdata` reflects `addr` combinationally.

Top module: `cmt_timer`

## Requirements
- R1: Channel c has a 32-bit counter and compare register when bit c of `WIDE_MASK` is set, and 16-bit ones otherwise. A 16-bit channel keeps only the low 16 bits of a counter or compare write and reads zero above them.
- R2: The start/stop register at address 0 holds one run bit per channel, with bit c for channel c. A channel's counter and prescaler advance only while its bit is set. Rewriting the register with another channel's bit changed leaves a channel's own count and timing untouched.
- R3: On each prescaled tick the counter adds one, except on the tick where it equals the compare value: then it becomes zero. The period is therefore the compare value plus one ticks.
- R4: A match sets the match flag, which is control bit 7 on a 16-bit channel and bit 15 on a 32-bit channel. On a 32-bit channel, a wrap from all ones to zero without a match sets a wrap flag at bit 14. A 16-bit channel has no wrap flag and reads zero in control bits 15:8.
- R5: A control write clears each flag whose written bit is 0 and leaves it unchanged where the bit is 1, so a write never sets a flag. The other control bits take the written value. A hardware set in the same cycle as the clear wins.
- R6: Control bits 1:0 select the tick divider: 0 selects /8, 1 selects /32, 2 selects /128 and 3 selects /512. Stopping a channel or changing the selection clears the prescaler. After the run bit is set, the first increment lands exactly one divider period of clock edges later.
- R7: A counter write is held pending and is applied on the clock edge of the second `slow_tick` pulse after the write. Until then reads return the old, still-advancing count. A new counter write while one is pending restarts the wait with the new value.
- R8: `irq[c]` is high exactly while control bit 6 (interrupt enable) of channel c is set and either of that channel's flags is set. Writing zero to the control register therefore drops the request.
- R9: After reset, every compare register holds all ones, and every counter, control register and the start/stop register hold zero.
- R10: Channel c's registers sit at address 4*(c+1): control at offset 0, counter at offset 1, compare at offset 2. Any other unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe of the slow reference clock, which gates counter writes |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
The hardest states to reach from the ports are the pending counter write that is overtaken by a second write, and the 32-bit wrap flag. The bench synchronises to the `slow_tick` pulses so that it can read the counter between the first and second pulse of each wait. It reaches the wrap by loading a count just below all ones, with the compare value set lower. Random trials with a fixed seed pick the channel, divider, compare value, enable and run length. Each trial starts from a stopped, cleared channel, so the bench can predict the count and flag exactly and confirm that the idle channel's count has not moved.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int PRE_W    = 9;
  localparam int CTRL_W   = 16;
  localparam int IE_BIT   = 6;
  localparam int FLAG_N   = 7;
  localparam int FLAG_W   = 15;
  localparam int WRAP_BIT = 14;

  typedef enum logic [1:0] {
    DIV8   = 2'd0,
    DIV32  = 2'd1,
    DIV128 = 2'd2,
    DIV512 = 2'd3
  } presel_e;

  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_CNT  = 2'd1,
    RG_CMP  = 2'd2,
    RG_NONE = 2'd3
  } reg_e;

  // terminal prescaler count for a selection: (8 << 2*sel) - 1
  function automatic logic [PRE_W-1:0] div_last(input presel_e s);
    logic [PRE_W:0] full;
    full = (10'd8 << (2 * int'(s))) - 10'd1;
    return full[PRE_W-1:0];
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  presel_e sel,
  output logic    tick
);

  logic [PRE_W-1:0] pcnt_q;
  presel_e          sel_q;
  logic             at_last;
  logic             sel_same;

  assign at_last  = (pcnt_q == div_last(sel));
  assign sel_same = (sel == sel_q);
  assign tick     = run && sel_same && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      sel_q  <= DIV8;
    end else begin
      sel_q <= sel;
      if (!run || !sel_same || at_last) pcnt_q <= '0;
      else                              pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R6
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt_q == '0));

endmodule

// File: rtl/cmt_count_core.sv
module cmt_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         slow_tick,
  input  logic         ld_req,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         match_evt,
  output logic         wrap_evt
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] pend_val_q;
  logic         pend_q;
  logic         seen_one_q;
  logic         ld_fire;

  assign ld_fire   = pend_q && slow_tick && seen_one_q && !ld_req;
  assign match_evt = tick && !ld_fire && (cnt_q == cmp);
  assign wrap_evt  = tick && !ld_fire && (cnt_q != cmp) && (&cnt_q);
  assign cnt       = cnt_q;

  // pending load: wait for two slow strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      seen_one_q <= 1'b0;
      pend_val_q <= '0;
    end else if (ld_req) begin
      pend_q     <= 1'b1;
      seen_one_q <= 1'b0;
      pend_val_q <= ld_val;
    end else if (pend_q && slow_tick) begin
      if (seen_one_q) begin
        pend_q     <= 1'b0;
        seen_one_q <= 1'b0;
      end else begin
        seen_one_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (ld_fire)   cnt_q <= pend_val_q;
    else if (match_evt) cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (cnt_q == '0));

  // R7
  load_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> (pend_q && !seen_one_q));

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> (cnt_q == $past(pend_val_q)));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_fire) |=> $stable(cnt_q));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        slow_tick,
  input  logic        wr_ctrl,
  input  logic        wr_cnt,
  input  logic        wr_cmp,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_rd,
  output logic [31:0] cnt_rd,
  output logic [31:0] cmp_rd,
  output logic        irq
);

  localparam int W    = WIDE ? 32 : 16;
  localparam int FBIT = WIDE ? FLAG_W : FLAG_N;
  localparam logic [CTRL_W-1:0] PLAIN_MASK = WIDE ? 16'h3FFF : 16'h007F;

  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      cmp_q;
  logic [W-1:0]      cnt;
  logic              match_flag_q;
  logic              wrap_flag;
  logic              tick;
  logic              match_evt;
  logic              wrap_evt;
  presel_e           sel;

  assign sel = presel_e'(ctrl_q[1:0]);

  cmt_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (sel),
    .tick  (tick)
  );

  cmt_count_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .slow_tick (slow_tick),
    .ld_req    (wr_cnt),
    .ld_val    (wdata[W-1:0]),
    .cmp       (cmp_q),
    .cnt       (cnt),
    .match_evt (match_evt),
    .wrap_evt  (wrap_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0] & PLAIN_MASK;
      if (wr_cmp)  cmp_q  <= wdata[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) match_flag_q <= 1'b0;
    else        match_flag_q <= (wr_ctrl ? (match_flag_q & wdata[FBIT]) : match_flag_q)
                                | match_evt;
  end

  generate
    if (WIDE) begin : g_wrap
      logic wrap_flag_q;
      always_ff @(posedge clk) begin
        if (!rst_n) wrap_flag_q <= 1'b0;
        else        wrap_flag_q <= (wr_ctrl ? (wrap_flag_q & wdata[WRAP_BIT]) : wrap_flag_q)
                                   | wrap_evt;
      end
      assign wrap_flag = wrap_flag_q;
    end else begin : g_nowrap
      assign wrap_flag = 1'b0;
    end
  endgenerate

  always_comb begin
    ctrl_rd           = 32'(ctrl_q);
    ctrl_rd[FBIT]     = match_flag_q;
    if (WIDE) ctrl_rd[WRAP_BIT] = wrap_flag;
  end

  assign cnt_rd = 32'(cnt);
  assign cmp_rd = 32'(cmp_q);
  assign irq    = ctrl_q[IE_BIT] && (match_flag_q || wrap_flag);

  // R4
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> match_flag_q);

  // R5
  write_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[FBIT] && !match_evt) |=> !match_flag_q);

  // R5
  write_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_flag_q && !match_evt) |=> !match_flag_q);

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_rd[IE_BIT]);

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int              NUM_CH    = 2,
  parameter logic [NUM_CH-1:0] WIDE_MASK = 2'b10,
  parameter int              ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int IDX_W = ADDR_W - 2;

  logic [NUM_CH-1:0] start_q;
  logic [NUM_CH-1:0] hit;
  logic [31:0]       ctrl_rd [NUM_CH];
  logic [31:0]       cnt_rd  [NUM_CH];
  logic [31:0]       cmp_rd  [NUM_CH];
  reg_e              rsel;
  logic              start_hit;

  assign rsel      = reg_e'(addr[1:0]);
  assign start_hit = (addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                  start_q <= '0;
    else if (wr_en && start_hit) start_q <= wdata[NUM_CH-1:0];
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign hit[c] = (addr[ADDR_W-1:2] == IDX_W'(c + 1));

      cmt_channel #(.WIDE(WIDE_MASK[c])) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (start_q[c]),
        .slow_tick (slow_tick),
        .wr_ctrl   (wr_en && hit[c] && rsel == RG_CTRL),
        .wr_cnt    (wr_en && hit[c] && rsel == RG_CNT),
        .wr_cmp    (wr_en && hit[c] && rsel == RG_CMP),
        .wdata     (wdata),
        .ctrl_rd   (ctrl_rd[c]),
        .cnt_rd    (cnt_rd[c]),
        .cmp_rd    (cmp_rd[c]),
        .irq       (irq[c])
      );
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (start_hit) rdata = 32'(start_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit[c]) begin
        case (rsel)
          RG_CTRL: rdata = ctrl_rd[c];
          RG_CNT:  rdata = cnt_rd[c];
          RG_CMP:  rdata = cmp_rd[c];
          default: rdata = '0;
        endcase
      end
    end
  end

  // R2
  start_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && start_hit) |=> (start_q == $past(wdata[NUM_CH-1:0])));

  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && start_hit) |=> $stable(start_q));

endmodule

// File: tb/cmt_timer_test.sv
module cmt_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  int slow_ctr = 0;

  always #5 clk = ~clk;

  cmt_timer #(.NUM_CH(2), .WIDE_MASK(2'b10), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // slow reference strobe: one cycle in sixteen
  initial forever begin
    @(negedge clk);
    slow_ctr  = (slow_ctr + 1) % 16;
    slow_tick = (slow_ctr == 15);
  end

  function automatic int divn(input int sel);
    return 8 << (2 * sel);
  endfunction

  function automatic int exp_cnt(input int k, input int sel, input int cmp);
    return (k / divn(sel)) % (cmp + 1);
  endfunction

  function automatic int exp_flag(input int k, input int sel, input int cmp);
    return ((k / divn(sel)) >= cmp + 1) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_slow();
    do @(posedge clk); while (!slow_tick);
    @(negedge clk);
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, oc;
    int unsigned seed;
    seed = 32'd4711;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 / R10 reset state and map
    rd(8'd0, v);  chk("R9 start reg", v, 0);
    rd(8'd4, v);  chk("R9 ctrl ch0", v, 0);
    rd(8'd5, v);  chk("R9 cnt ch0", v, 0);
    rd(8'd6, v);  chk("R9 cmp ch0 narrow", v, 32'h0000FFFF);
    rd(8'd10, v); chk("R9 cmp ch1 wide", v, 32'hFFFFFFFF);
    chk("R9 irq", {30'd0, irq}, 0);
    rd(8'd3, v);  chk("R10 unmapped", v, 0);
    rd(8'd7, v);  chk("R10 unused offset", v, 0);

    // R1 width truncation
    wr(8'd6, 32'h00012345);  rd(8'd6, v);  chk("R1 narrow cmp", v, 32'h2345);
    wr(8'd10, 32'h00012345); rd(8'd10, v); chk("R1 wide cmp", v, 32'h12345);

    // R7 delayed counter write, and restart by a second write
    wait_slow();
    wr(8'd5, 32'h0000ABCD);
    rd(8'd5, v); chk("R7 old before strobes", v, 0);
    wait_slow(); rd(8'd5, v); chk("R7 old after one strobe", v, 0);
    wait_slow(); rd(8'd5, v); chk("R7 applied on second strobe", v, 32'hABCD);
    wr(8'd5, 32'h1111);
    wait_slow(); rd(8'd5, v); chk("R7 pending one strobe", v, 32'hABCD);
    wr(8'd5, 32'h2222);
    wait_slow(); rd(8'd5, v); chk("R7 restarted wait", v, 32'hABCD);
    wait_slow(); rd(8'd5, v); chk("R7 newest value", v, 32'h2222);

    // R4 wide wrap flag at bit 14
    wr(8'd8, 32'h40); wr(8'd10, 5); wr(8'd9, 32'hFFFFFFFE); edges(40);
    wr(8'd0, 32'h2); edges(16);
    rd(8'd9, v); chk("R4 wide wrapped count", v, 0);
    rd(8'd8, v); chk("R4 wide wrap flag", v, 32'h4040);
    chk("R8 irq from wrap flag", {31'd0, irq[1]}, 1);
    wr(8'd0, 0);
    // R4 narrow wrap sets nothing
    wr(8'd4, 32'h40); wr(8'd6, 5); wr(8'd5, 32'hFFFE); edges(40);
    wr(8'd0, 32'h1); edges(16);
    rd(8'd5, v); chk("R4 narrow wrapped count", v, 0);
    rd(8'd4, v); chk("R4 narrow no wrap flag", v, 32'h40);
    chk("R8 narrow no irq", {31'd0, irq[0]}, 0);
    wr(8'd0, 0);

    // R5 writing ones cannot set, zeros clear
    wr(8'd8, 32'hC040); rd(8'd8, v); chk("R5 ones keep flags", v, 32'h4040);
    wr(8'd8, 32'h0041); rd(8'd8, v); chk("R5 zeros clear both", v, 32'h0041);
    chk("R8 irq drops on clear", {31'd0, irq[1]}, 0);

    // R8 match then control write of zero
    wr(8'd8, 32'h40); wr(8'd10, 2); wr(8'd9, 0); edges(40);
    wr(8'd0, 32'h2); edges(24); wr(8'd0, 0);
    rd(8'd8, v); chk("R4 wide match flag bit15", v, 32'h8040);
    chk("R8 irq on match", {31'd0, irq[1]}, 1);
    wr(8'd8, 0); rd(8'd8, v); chk("R8 ctrl zero", v, 0);
    chk("R8 irq off after zero", {31'd0, irq[1]}, 0);

    // R2 stopping one channel leaves the other running
    wr(8'd4, 0); wr(8'd8, 0); wr(8'd6, 1000); wr(8'd10, 1000);
    wr(8'd5, 0); wr(8'd9, 0); edges(40);
    wr(8'd0, 32'h3); edges(80); wr(8'd0, 32'h2); edges(80);
    rd(8'd5, v); chk("R2 stopped channel frozen", v, 10);
    rd(8'd9, v); chk("R2 other channel ran on", v, 20);
    wr(8'd0, 0);

    // R3 / R6 random trials
    for (int t = 0; t < 24; t++) begin
      int ch, sel, cmp, ie, k, base, other, fb;
      ch    = $urandom % 2;
      sel   = $urandom % 4;
      cmp   = $urandom % 12;
      ie    = $urandom % 2;
      k     = $urandom % 1500;
      if (t < 4) k = divn(sel) * (cmp + 1);
      base  = 4 * (ch + 1);
      other = 4 * (2 - ch);
      fb    = ch ? 15 : 7;
      wr(8'd0, 0);
      wr(8'(base), 32'((ie << 6) | sel));
      wr(8'(base + 2), 32'(cmp));
      wr(8'(base + 1), 0);
      edges(40);
      rd(8'(other + 1), oc);
      wr(8'd0, 32'(1 << ch));
      edges(k);
      rd(8'(base + 1), v);
      chk("R3 R6 count", v, 32'(exp_cnt(k, sel, cmp)));
      rd(8'(base), v);
      chk("R4 R5 ctrl", v, 32'((ie << 6) | sel | (exp_flag(k, sel, cmp) << fb)));
      chk("R8 irq", {31'd0, irq[ch]}, 32'(ie & exp_flag(k, sel, cmp)));
      rd(8'(other + 1), v);
      chk("R2 idle channel", v, oc);
    end
    wr(8'd0, 0);
    finish_run();
  end

endmodule